// File: doc/BRIEF.md
# Inter-Processor Flag and Interrupt Register Unit

This block lets the cores of a small multi-core cluster signal one another through memory-mapped registers. Each destination core owns a pair of registers: a posting register and a clearing register. A sending core writes the posting register of the core it wants to reach. Every 1 in the 28-bit flag field of that write is added to the flags already stored. A 1 in the trigger bit also sends a single-cycle interrupt pulse to that core. The receiving core reads the flag field to decide what to do, then writes the clearing register with 1s in the bits it has handled.

Several bus ports reach the registers, one per requester, and each port takes one write per cycle. A write takes effect at the next clock edge. Reads are combinational and need no cache or coherency step. When two ports touch the same destination in one cycle, their posts are merged. If a post and a clear hit the same bit in one cycle, the post wins, so an event raised in that cycle is never lost.

Top module: `ipi_flag_regs`

## Requirements
- R1: After reset every flag bit reads 0 through every register and every interrupt output is 0.
- R2: The port word address selects the register. Address a with a < NUM_CORES is the posting register of core a. Address NUM_CORES + c is the clearing register of core c. Any other address reads 0, and a write to it changes nothing. With the defaults, addresses 0 to 3 post and addresses 4 to 7 clear.
- R3: A write to a posting register ORs write-data bits [31:4] into that core's stored flags. Written 0s leave the stored bits unchanged. The new value can be read from the cycle after the write edge.
- R4: A write to a clearing register sets to 0 every stored flag bit whose write-data bit in [31:4] is 1. Bits written as 0 keep their value.
- R5: A posting write with write-data bit 0 equal to 1 drives irq_o[core] high for exactly the one cycle that follows the write edge. A posting write with bit 0 equal to 0 gives no pulse, and neither does any write to a clearing register.
- R6: Bits [3:0] of read data are always 0. Write-data bits [3:1] are ignored, and bit 0 is never stored.
- R7: A read of either the posting or the clearing address of core c returns core c's flags in bits [31:4]. Read data follows the address in the same cycle.
- R8: If one port posts a bit and another port clears that same bit in the same cycle, the bit ends up 1. Bits that are only cleared in that cycle still end up 0.
- R9: Posting writes from several ports to one core in the same cycle OR their bits together. Trigger bits from several ports in the same cycle give a single one-cycle pulse.
- R10: A write changes only the flags and interrupt output of the core it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | NUM_PORTS | Write enable, one bit per bus port |
| addr_i | input | NUM_PORTS*ADDR_W | Word address per port; port p occupies bits [p*ADDR_W +: ADDR_W] |
| wdata_i | input | NUM_PORTS*DATA_W | Write data per port; port p occupies bits [p*DATA_W +: DATA_W] |
| rdata_o | output | NUM_PORTS*DATA_W | Combinational read data per port |
| irq_o | output | NUM_CORES | One-cycle interrupt pulse per destination core |

## Verification
A post and a clear can land on the same flag bit in the same cycle, and so can two trigger writes to the same core. The bench makes both happen by driving port 0 and port 1 in the same clock period: once with overlapping set and clear masks, and once with the trigger bit set on both ports. It then checks that the overlapping bit survives while a bit that is only cleared drops, and that irq_o shows exactly one pulse one cycle wide. The checker also tests every such cycle: a posted bit must be 1 after the edge, and a bit that is cleared but not posted must be 0.

// File: rtl/ipi_flag_pkg.sv
package ipi_flag_pkg;

   // Lowest bit of the flag field; bits below it are trigger and reserved.
   localparam int FLAG_LSB_DEF = 4;
   // Bit that requests an interrupt pulse on a posting write.
   localparam int TRIG_BIT     = 0;

   // Address bits needed for a posting bank and a clearing bank.
   function automatic int addr_bits(input int cores);
      int n;
      n = $clog2(2 * cores);
      return (n < 1) ? 1 : n;
   endfunction

endpackage

// File: rtl/ipi_flag_decode.sv
module ipi_flag_decode #(
   parameter  int NUM_CORES = 4,
   parameter  int DATA_W    = 32,
   parameter  int FLAG_LSB  = 4,
   parameter  int ADDR_W    = 3,
   localparam int FLAG_W    = DATA_W - FLAG_LSB
) (
   input  logic                        we_i,
   input  logic [ADDR_W-1:0]           addr_i,
   input  logic [DATA_W-1:0]           wdata_i,
   output logic [NUM_CORES*FLAG_W-1:0] set_o,
   output logic [NUM_CORES*FLAG_W-1:0] clr_o,
   output logic [NUM_CORES-1:0]        trig_o
);

   logic [FLAG_W-1:0] field;
   logic              unused_rsv;

   assign field      = wdata_i[DATA_W-1:FLAG_LSB];
   assign unused_rsv = ^wdata_i[FLAG_LSB-1:ipi_flag_pkg::TRIG_BIT+1];

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      logic hit_post;
      logic hit_clear;
      assign hit_post  = we_i && (addr_i == ADDR_W'(c));
      assign hit_clear = we_i && (addr_i == ADDR_W'(NUM_CORES + c));
      assign set_o[c*FLAG_W +: FLAG_W] = hit_post  ? field : '0;
      assign clr_o[c*FLAG_W +: FLAG_W] = hit_clear ? field : '0;
      assign trig_o[c] = hit_post && wdata_i[ipi_flag_pkg::TRIG_BIT];
   end

endmodule

// File: rtl/ipi_flag_cell.sv
module ipi_flag_cell #(
   parameter int FLAG_W = 28
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [FLAG_W-1:0] set_i,
   input  logic [FLAG_W-1:0] clr_i,
   input  logic              trig_i,
   output logic [FLAG_W-1:0] flag_o,
   output logic              irq_o
);

   logic [FLAG_W-1:0] flag_q;
   logic              irq_q;

   // Clear first, then set, so a same-cycle post is kept.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         flag_q <= (flag_q & ~clr_i) | set_i;
         irq_q  <= trig_i;
      end
   end

   assign flag_o = flag_q;
   assign irq_o  = irq_q;

endmodule

// File: rtl/ipi_flag_rdmux.sv
module ipi_flag_rdmux #(
   parameter  int NUM_CORES = 4,
   parameter  int DATA_W    = 32,
   parameter  int FLAG_LSB  = 4,
   parameter  int ADDR_W    = 3,
   localparam int FLAG_W    = DATA_W - FLAG_LSB
) (
   input  logic [NUM_CORES*FLAG_W-1:0] flag_state_i,
   input  logic [ADDR_W-1:0]           addr_i,
   output logic [DATA_W-1:0]           rdata_o
);

   always_comb begin
      rdata_o = '0;
      for (int c = 0; c < NUM_CORES; c++) begin
         if (addr_i == ADDR_W'(c) || addr_i == ADDR_W'(NUM_CORES + c)) begin
            rdata_o = {flag_state_i[c*FLAG_W +: FLAG_W], {FLAG_LSB{1'b0}}};
         end
      end
   end

endmodule

// File: rtl/ipi_flag_regs.sv
module ipi_flag_regs #(
   parameter  int NUM_CORES = 4,
   parameter  int NUM_PORTS = 2,
   parameter  int DATA_W    = 32,
   parameter  int FLAG_LSB  = ipi_flag_pkg::FLAG_LSB_DEF,
   localparam int ADDR_W    = ipi_flag_pkg::addr_bits(NUM_CORES),
   localparam int FLAG_W    = DATA_W - FLAG_LSB
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic [NUM_PORTS-1:0]        we_i,
   input  logic [NUM_PORTS*ADDR_W-1:0] addr_i,
   input  logic [NUM_PORTS*DATA_W-1:0] wdata_i,
   output logic [NUM_PORTS*DATA_W-1:0] rdata_o,
   output logic [NUM_CORES-1:0]        irq_o
);

   // Elaboration-time parameter checks
   if (NUM_CORES < 1) begin : g_bad_cores
      $error("ipi_flag_regs: NUM_CORES must be at least 1");
   end
   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("ipi_flag_regs: NUM_PORTS must be at least 1");
   end
   if (FLAG_LSB <= ipi_flag_pkg::TRIG_BIT + 1 || FLAG_LSB >= DATA_W) begin : g_bad_lsb
      $error("ipi_flag_regs: FLAG_LSB must lie above the trigger bit and below DATA_W");
   end

   logic [NUM_CORES*FLAG_W-1:0] p_set  [NUM_PORTS];
   logic [NUM_CORES*FLAG_W-1:0] p_clr  [NUM_PORTS];
   logic [NUM_CORES-1:0]        p_trig [NUM_PORTS];

   logic [NUM_CORES*FLAG_W-1:0] set_all;
   logic [NUM_CORES*FLAG_W-1:0] clr_all;
   logic [NUM_CORES-1:0]        trig_all;
   logic [NUM_CORES*FLAG_W-1:0] flag_state;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      ipi_flag_decode #(
         .NUM_CORES (NUM_CORES),
         .DATA_W    (DATA_W),
         .FLAG_LSB  (FLAG_LSB),
         .ADDR_W    (ADDR_W)
      ) u_decode (
         .we_i    (we_i[p]),
         .addr_i  (addr_i[p*ADDR_W +: ADDR_W]),
         .wdata_i (wdata_i[p*DATA_W +: DATA_W]),
         .set_o   (p_set[p]),
         .clr_o   (p_clr[p]),
         .trig_o  (p_trig[p])
      );

      ipi_flag_rdmux #(
         .NUM_CORES (NUM_CORES),
         .DATA_W    (DATA_W),
         .FLAG_LSB  (FLAG_LSB),
         .ADDR_W    (ADDR_W)
      ) u_rdmux (
         .flag_state_i (flag_state),
         .addr_i       (addr_i[p*ADDR_W +: ADDR_W]),
         .rdata_o      (rdata_o[p*DATA_W +: DATA_W])
      );
   end

   // Merge the requests of all ports
   always_comb begin
      set_all  = '0;
      clr_all  = '0;
      trig_all = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         set_all  = set_all  | p_set[p];
         clr_all  = clr_all  | p_clr[p];
         trig_all = trig_all | p_trig[p];
      end
   end

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      ipi_flag_cell #(
         .FLAG_W (FLAG_W)
      ) u_cell (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .set_i  (set_all[c*FLAG_W +: FLAG_W]),
         .clr_i  (clr_all[c*FLAG_W +: FLAG_W]),
         .trig_i (trig_all[c]),
         .flag_o (flag_state[c*FLAG_W +: FLAG_W]),
         .irq_o  (irq_o[c])
      );
   end

endmodule

// File: rtl/ipi_flag_regs_chk.sv
module ipi_flag_regs_chk #(
   parameter  int NUM_CORES = 4,
   parameter  int NUM_PORTS = 2,
   parameter  int DATA_W    = 32,
   parameter  int FLAG_LSB  = 4,
   localparam int ADDR_W    = ipi_flag_pkg::addr_bits(NUM_CORES),
   localparam int FLAG_W    = DATA_W - FLAG_LSB
) (
   input logic                        clk_i,
   input logic                        rst_ni,
   input logic [NUM_PORTS-1:0]        we_i,
   input logic [NUM_PORTS*ADDR_W-1:0] addr_i,
   input logic [NUM_PORTS*DATA_W-1:0] wdata_i,
   input logic [NUM_PORTS*DATA_W-1:0] rdata_o,
   input logic [NUM_CORES-1:0]        irq_o,
   input logic [NUM_CORES*FLAG_W-1:0] flag_state
);

   logic [FLAG_W-1:0] set_any  [NUM_CORES];
   logic [FLAG_W-1:0] clr_any  [NUM_CORES];
   logic              trig_any [NUM_CORES];
   logic              unused_chk;

   assign unused_chk = ^{rdata_o, wdata_i};

   // Independent decode of the port requests
   always_comb begin
      for (int c = 0; c < NUM_CORES; c++) begin
         set_any[c]  = '0;
         clr_any[c]  = '0;
         trig_any[c] = 1'b0;
         for (int p = 0; p < NUM_PORTS; p++) begin
            if (we_i[p] && addr_i[p*ADDR_W +: ADDR_W] == ADDR_W'(c)) begin
               set_any[c]  = set_any[c] | wdata_i[p*DATA_W+FLAG_LSB +: FLAG_W];
               trig_any[c] = trig_any[c] | wdata_i[p*DATA_W];
            end
            if (we_i[p] && addr_i[p*ADDR_W +: ADDR_W] == ADDR_W'(NUM_CORES + c)) begin
               clr_any[c] = clr_any[c] | wdata_i[p*DATA_W+FLAG_LSB +: FLAG_W];
            end
         end
      end
   end

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      // R5
      irq_follows_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         trig_any[c] |=> irq_o[c]);
      // R5
      irq_has_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         irq_o[c] |-> $past(trig_any[c]));
      // R8
      post_sticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (set_any[c] != '0) |=>
         ((flag_state[c*FLAG_W +: FLAG_W] & $past(set_any[c])) == $past(set_any[c])));
      // R4
      clear_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ((clr_any[c] & ~set_any[c]) != '0) |=>
         ((flag_state[c*FLAG_W +: FLAG_W] & $past(clr_any[c] & ~set_any[c])) == '0));
      // R10
      idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (set_any[c] == '0 && clr_any[c] == '0) |=> $stable(flag_state[c*FLAG_W +: FLAG_W]));
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      // R6
      rsv_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         rdata_o[p*DATA_W +: FLAG_LSB] == '0);
   end

endmodule

bind ipi_flag_regs ipi_flag_regs_chk #(
   .NUM_CORES (NUM_CORES),
   .NUM_PORTS (NUM_PORTS),
   .DATA_W    (DATA_W),
   .FLAG_LSB  (FLAG_LSB)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .we_i       (we_i),
   .addr_i     (addr_i),
   .wdata_i    (wdata_i),
   .rdata_o    (rdata_o),
   .irq_o      (irq_o),
   .flag_state (flag_state)
);

// File: tb/ipi_flag_regs_bench.sv
module ipi_flag_regs_bench;

   localparam int NC = 4;
   localparam int NP = 2;
   localparam int DW = 32;
   localparam int AW = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NP-1:0]    we = '0;
   logic [NP*AW-1:0] addr = '0;
   logic [NP*DW-1:0] wdata = '0;
   logic [NP*DW-1:0] rdata;
   logic [NC-1:0]    irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   ipi_flag_regs u_ipi_flag_regs (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .we_i    (we),
      .addr_i  (addr),
      .wdata_i (wdata),
      .rdata_o (rdata),
      .irq_o   (irq)
   );

   typedef struct packed {
      logic        wp;
      logic [2:0]  wa;
      logic [31:0] wd;
      logic [2:0]  ra;
      logic [31:0] exp;
   } vec_t;

   // Post addresses 0..3, clear addresses 4..7
   localparam vec_t VECS [10] = '{
      '{1'b0, 3'd1, 32'h0000_00F0, 3'd1, 32'h0000_00F0},  // R3 first post
      '{1'b0, 3'd1, 32'h0000_0F00, 3'd5, 32'h0000_0FF0},  // R3 OR merge, R7 read via clear addr
      '{1'b1, 3'd5, 32'h0000_0030, 3'd1, 32'h0000_0FC0},  // R4 partial clear
      '{1'b0, 3'd1, 32'h0000_000E, 3'd1, 32'h0000_0FC0},  // R6 reserved bits ignored
      '{1'b1, 3'd2, 32'hFFFF_FFFE, 3'd2, 32'hFFFF_FFF0},  // R6 full post, low nibble zero
      '{1'b0, 3'd6, 32'h0000_0000, 3'd6, 32'hFFFF_FFF0},  // R4 zero clear keeps
      '{1'b1, 3'd6, 32'hFFFF_000F, 3'd2, 32'h0000_FFF0},  // R4 upper clear
      '{1'b1, 3'd3, 32'hA000_0000, 3'd1, 32'h0000_0FC0},  // R10 other core untouched
      '{1'b0, 3'd5, 32'hFFFF_FFFF, 3'd1, 32'h0000_0000},  // R4 clear all
      '{1'b0, 3'd7, 32'h0000_0000, 3'd7, 32'hA000_0000}   // R7 read core 3 via clear addr
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] rd(input int p);
      return rdata[p*DW +: DW];
   endfunction

   task automatic set_port(input int p, input int a, input logic [31:0] d);
      we[p]            = 1'b1;
      addr[p*AW +: AW] = AW'(a);
      wdata[p*DW +: DW] = d;
   endtask

   // Drive at negedge, commit at posedge, release at the next negedge
   task automatic commit();
      @(posedge clk);
      @(negedge clk);
      we = '0;
   endtask

   task automatic read_chk(input string req, input int p, input int a, input logic [31:0] exp);
      addr[p*AW +: AW] = AW'(a);
      #1;
      check(req, rd(p), exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 2*NC; a++) read_chk("R1 reset flags", 0, a, 32'h0);
      check("R1 reset irq", {28'h0, irq}, 32'h0);

      // Vector table
      for (int i = 0; i < 10; i++) begin
         set_port(int'(VECS[i].wp), int'(VECS[i].wa), VECS[i].wd);
         commit();
         read_chk($sformatf("R3/R4/R6/R7/R10 vector %0d", i), 0, int'(VECS[i].ra), VECS[i].exp);
      end

      // R2 same register seen from both ports in one cycle
      addr[0 +: AW] = 3'd3;
      addr[AW +: AW] = 3'd7;
      #1;
      check("R2 port1 read", rd(1), rd(0));

      // R5 trigger pulse
      set_port(1, 2, 32'h0000_0001);
      commit();
      check("R5 irq high one cycle after write", {28'h0, irq}, 32'h4);
      @(negedge clk);
      check("R5 irq back low", {28'h0, irq}, 32'h0);
      read_chk("R6 trigger bit not stored", 0, 2, 32'h0000_FFF0);

      // R5 no pulse from clear write with bit 0 or post without it
      set_port(0, 4, 32'h0000_0001);
      set_port(1, 1, 32'h0000_1000);
      commit();
      check("R5 no pulse from clear or untriggered post", {28'h0, irq}, 32'h0);
      read_chk("R3 post with no trigger", 0, 1, 32'h0000_1000);

      // R8 same-cycle post and clear on the same core
      set_port(0, 0, 32'h0000_0030);
      commit();
      set_port(0, 0, 32'h0000_0010);
      set_port(1, 4, 32'h0000_0030);
      commit();
      read_chk("R8 post wins, clear-only bit drops", 0, 0, 32'h0000_0010);

      // R9 two ports post and trigger the same core together
      set_port(0, 3, 32'h0000_0101);
      set_port(1, 3, 32'h0000_0201);
      commit();
      check("R9 single pulse", {28'h0, irq}, 32'h8);
      read_chk("R9 merged posts", 0, 3, 32'hA000_0300);
      @(negedge clk);
      check("R9 pulse one cycle wide", {28'h0, irq}, 32'h0);
      read_chk("R10 core 1 unchanged", 1, 1, 32'h0000_1000);

      // R1 reset in mid-run
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      read_chk("R1 flags cleared by reset", 0, 3, 32'h0);
      read_chk("R1 flags cleared by reset", 1, 6, 32'h0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule